// File: doc/BRIEF.md
# BCD Clock Calendar Counter Chain

This block keeps time of day and calendar date in a row of byte-wide registers. A single-cycle enable arrives at 100 Hz and advances the hundredths register. Whenever a unit rolls over, the carry ripples through seconds, minutes and hours to the calendar fields, all in the same clock cycle. The date and the weekday/month are each packed into one byte. The block follows a four-year leap cycle driven by a two-bit year, and it can show hours in either a 24-hour or a 12-hour form.

A host bus can load any single register directly. A stop input freezes the chain so that the time can be loaded safely. When event mode is selected, the three lowest registers instead hold a six-digit BCD count that advances on an external event enable. In that mode the 100 Hz enable has no effect.

Top module: `rtc_count_chain`

## Requirements
- R1: After reset the outputs read hundredths 8'h00, seconds 8'h00, minutes 8'h00 and hours 8'h00 (24-hour form). The year/date byte reads 8'h01 (year 0, date 01) and the weekday/month byte reads 8'h01 (weekday 0, month 01).
- R2: In clock mode each accepted tick adds one to the BCD hundredths. The step from 99 to 00 advances the seconds. Seconds and minutes each count 00 to 59, and the step from 59 to 00 advances the next unit.
- R3: When hours bit 7 is 0 (24-hour form), hours bits 5:0 count BCD 00 to 23. The step from 23 to 00 advances the day.
- R4: When hours bit 7 is 1 (12-hour form), bit 6 marks PM and bits 4:0 hold BCD 01 to 12. The order is 12, 01 … 11, then 12 again, and bit 6 flips only on the 11 to 12 step. The step from 11 PM to 12 AM is the only one that advances the day.
- R5: The year/date byte holds the BCD date in bits 5:0. The weekday/month byte holds the BCD month in bits 4:0. Months 4, 6, 9 and 11 end at 30. Months 1, 3, 5, 7, 8, 10 and 12 end at 31. After the last date the date returns to 01 and the month advances.
- R6: The year sits in bits 7:6 of the year/date byte. February ends at 29 when the year is 0 and at 28 when the year is 1, 2 or 3.
- R7: After month 12 the month returns to 01 and the year advances modulo 4. The weekday sits in bits 7:5 of the weekday/month byte. It advances once per day, from 0 to 6 and then back to 0.
- R8: While stopCount is 1, ticks and events are ignored and every register holds its value.
- R9: A write with address 1 to 6 (hundredths, seconds, minutes, hours, year/date, weekday/month) loads only that byte. No tick or event takes effect in the same cycle. A write to address 0 or 7 changes nothing.
- R10: When eventMode is 1, each eventEn adds one to a six-digit BCD count. Byte 1 holds digits D1:D0, byte 2 holds D3:D2 and byte 3 holds D5:D4. The count 999999 wraps to 000000. In this mode tickEn is ignored and bytes 4 to 6 hold their values.
- R11: In clock mode (eventMode 0), eventEn has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | 100 Hz advance enable, one cycle wide |
| eventEn | input | 1 | External event enable, one cycle wide |
| eventMode | input | 1 | 1 selects event-counter mode |
| stopCount | input | 1 | 1 freezes counting |
| wrEn | input | 1 | Host write strobe |
| wrAddr | input | 3 | Host write address, 1 to 6 valid |
| wrData | input | 8 | Host write data |
| hundredthsQ | output | 8 | Hundredths, or event digits D1:D0 |
| secondsQ | output | 8 | Seconds, or event digits D3:D2 |
| minutesQ | output | 8 | Minutes, or event digits D5:D4 |
| hoursQ | output | 8 | Format, PM flag and BCD hours |
| yearDateQ | output | 8 | Year in bits 7:6, BCD date in bits 5:0 |
| dayMonthQ | output | 8 | Weekday in bits 7:5, BCD month in bits 4:0 |

## Verification
Every register is visible at the ports, so a wrong carry decision appears on the output byte in the clock cycle right after the tick that should have caused it. The risky decisions all sit on rollover boundaries: the last-date lookup for each month, the February case for each year value, the PM flip in 12-hour form and the year wrap. The stimulus therefore loads the state just before each boundary, applies one tick and compares all six bytes. This way a missed or spurious carry anywhere in the chain is caught in the cycle it happens.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NUM_REGS  = 6;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 3;
  localparam int EVT_BYTES = 3;
  localparam int IDX_HUN   = 0;
  localparam int IDX_SEC   = 1;
  localparam int IDX_MIN   = 2;
  localparam int IDX_HOUR  = 3;
  localparam int IDX_YDATE = 4;
  localparam int IDX_WMON  = 5;
  localparam int BASE_ADDR = 1;

  typedef struct packed {
    logic                clkStep;
    logic                evtStep;
    logic [NUM_REGS-1:0] wrSel;
  } rtcStrobe_t;

  function automatic logic [7:0] bcdNext(input logic [7:0] v);
    if (v[3:0] == 4'd9) bcdNext = {v[7:4] + 4'd1, 4'd0};
    else                bcdNext = {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic [5:0] monthLast(input logic [4:0] mon, input logic [1:0] yr);
    case (mon)
      5'h04, 5'h06, 5'h09, 5'h11: monthLast = 6'h30;
      5'h02:                      monthLast = (yr == 2'd0) ? 6'h29 : 6'h28;
      default:                    monthLast = 6'h31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic              tickEn,
  input  logic              eventEn,
  input  logic              eventMode,
  input  logic              stopCount,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  output rtcStrobe_t        strobe
);
  logic quiet;
  assign quiet = stopCount | wrEn;

  always_comb begin
    strobe.clkStep = tickEn & ~eventMode & ~quiet;
    strobe.evtStep = eventEn & eventMode & ~quiet;
    for (int i = 0; i < NUM_REGS; i++) begin
      strobe.wrSel[i] = wrEn && (int'(wrAddr) == BASE_ADDR + i);
    end
  end
endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
(
  input  logic                              clk,
  input  logic                              rstN,
  input  rtcStrobe_t                        strobe,
  input  logic [BYTE_W-1:0]                 wrData,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]   regQ
);
  localparam logic [NUM_REGS-1:0][BYTE_W-1:0] RESET_VAL =
    {8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00};

  logic [NUM_REGS-1:0][BYTE_W-1:0] nxtVal;
  logic [NUM_REGS-1:0]             incEn;

  logic [7:0] hun, sec, mins, hour, ydate, wmon;
  logic [7:0] hourBcd, dateBcd, monBcd, hourNext;
  logic [5:0] dateNext;
  logic [4:0] monNext;
  logic [1:0] yrNext;
  logic [2:0] wdNext;
  logic hunWrap, secWrap, minWrap, dayEnd, dateWrap, monWrap;
  logic minStep, dayStep, monStep, yrStep, carry;

  assign hun   = regQ[IDX_HUN];
  assign sec   = regQ[IDX_SEC];
  assign mins  = regQ[IDX_MIN];
  assign hour  = regQ[IDX_HOUR];
  assign ydate = regQ[IDX_YDATE];
  assign wmon  = regQ[IDX_WMON];

  always_comb begin
    hunWrap = (hun == 8'h99);
    secWrap = (sec == 8'h59);
    minWrap = (mins == 8'h59);
    hourBcd = bcdNext({2'b00, hour[5:0]});
    hourNext = hour;
    dayEnd   = 1'b0;
    if (!hour[7]) begin
      if (hour[5:0] == 6'h23) begin
        hourNext = 8'h00;
        dayEnd   = 1'b1;
      end else begin
        hourNext = {2'b00, hourBcd[5:0]};
      end
    end else if (hour[4:0] == 5'h12) begin
      hourNext = {1'b1, hour[6], 6'h01};
    end else if (hour[4:0] == 5'h11) begin
      hourNext = {1'b1, ~hour[6], 6'h12};
      dayEnd   = hour[6];
    end else begin
      hourNext = {1'b1, hour[6], hourBcd[5:0]};
    end

    dateWrap = (ydate[5:0] == monthLast(wmon[4:0], ydate[7:6]));
    dateBcd  = bcdNext({2'b00, ydate[5:0]});
    dateNext = dateWrap ? 6'h01 : dateBcd[5:0];
    monWrap  = (wmon[4:0] == 5'h12);
    monBcd   = bcdNext({3'b000, wmon[4:0]});
    monNext  = monWrap ? 5'h01 : monBcd[4:0];
    yrNext   = ydate[7:6] + 2'd1;
    wdNext   = (wmon[7:5] == 3'd6) ? 3'd0 : wmon[7:5] + 3'd1;

    minStep = strobe.clkStep & hunWrap & secWrap;
    dayStep = minStep & minWrap & dayEnd;
    monStep = dayStep & dateWrap;
    yrStep  = monStep & monWrap;

    incEn[IDX_HUN]   = strobe.clkStep;
    incEn[IDX_SEC]   = strobe.clkStep & hunWrap;
    incEn[IDX_MIN]   = minStep;
    incEn[IDX_HOUR]  = minStep & minWrap;
    incEn[IDX_YDATE] = dayStep;
    incEn[IDX_WMON]  = dayStep;
    nxtVal[IDX_HUN]   = hunWrap ? 8'h00 : bcdNext(hun);
    nxtVal[IDX_SEC]   = secWrap ? 8'h00 : bcdNext(sec);
    nxtVal[IDX_MIN]   = minWrap ? 8'h00 : bcdNext(mins);
    nxtVal[IDX_HOUR]  = hourNext;
    nxtVal[IDX_YDATE] = {yrStep ? yrNext : ydate[7:6], dateNext};
    nxtVal[IDX_WMON]  = {wdNext, monStep ? monNext : wmon[4:0]};

    carry = 1'b1;
    if (strobe.evtStep) begin
      for (int i = 0; i < EVT_BYTES; i++) begin
        incEn[i]  = carry;
        nxtVal[i] = (regQ[i] == 8'h99) ? 8'h00 : bcdNext(regQ[i]);
        carry     = carry & (regQ[i] == 8'h99);
      end
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                q <= RESET_VAL[g];
      else if (strobe.wrSel[g]) q <= wrData;
      else if (incEn[g])        q <= nxtVal[g];
    end
    assign regQ[g] = q;
  end
endmodule

// File: rtl/rtc_count_chain.sv
module rtc_count_chain
  import rtc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              eventEn,
  input  logic              eventMode,
  input  logic              stopCount,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [BYTE_W-1:0] wrData,
  output logic [BYTE_W-1:0] hundredthsQ,
  output logic [BYTE_W-1:0] secondsQ,
  output logic [BYTE_W-1:0] minutesQ,
  output logic [BYTE_W-1:0] hoursQ,
  output logic [BYTE_W-1:0] yearDateQ,
  output logic [BYTE_W-1:0] dayMonthQ
);
  rtcStrobe_t                      strobe;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regQ;

  rtc_ctrl i_ctrl (
    .tickEn(tickEn), .eventEn(eventEn), .eventMode(eventMode),
    .stopCount(stopCount), .wrEn(wrEn), .wrAddr(wrAddr), .strobe(strobe)
  );

  rtc_datapath i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData), .regQ(regQ)
  );

  assign hundredthsQ = regQ[IDX_HUN];
  assign secondsQ    = regQ[IDX_SEC];
  assign minutesQ    = regQ[IDX_MIN];
  assign hoursQ      = regQ[IDX_HOUR];
  assign yearDateQ   = regQ[IDX_YDATE];
  assign dayMonthQ   = regQ[IDX_WMON];
endmodule

// File: rtl/rtc_chain_chk.sv
module rtc_chain_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tickEn,
  input logic       eventEn,
  input logic       eventMode,
  input logic       stopCount,
  input logic       wrEn,
  input logic [2:0] wrAddr,
  input logic [7:0] wrData,
  input logic [7:0] hundredthsQ,
  input logic [7:0] secondsQ,
  input logic [7:0] minutesQ,
  input logic [7:0] hoursQ,
  input logic [7:0] yearDateQ,
  input logic [7:0] dayMonthQ
);
  logic clkTick;
  logic [47:0] allQ;
  assign clkTick = tickEn && !eventMode && !stopCount && !wrEn;
  assign allQ = {hundredthsQ, secondsQ, minutesQ, hoursQ, yearDateQ, dayMonthQ};

  AST_HUN_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (clkTick && hundredthsQ == 8'h99) |=> (hundredthsQ == 8'h00)); // R2
  AST_SEC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (clkTick && hundredthsQ != 8'h99) |=> $stable(secondsQ)); // R2
  AST_HOUR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (clkTick && hundredthsQ == 8'h99 && secondsQ == 8'h59 && minutesQ == 8'h59
     && hoursQ == 8'h23) |=> (hoursQ == 8'h00)); // R3
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (stopCount && !wrEn) |=> $stable(allQ)); // R8
  AST_WR_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == 3'd2) |=> (secondsQ == $past(wrData))); // R9
  AST_WR_ISOLATE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr != 3'd1) |=> $stable(hundredthsQ)); // R9
  AST_EVT_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (eventMode && !eventEn && !wrEn) |=> $stable(allQ)); // R10
  AST_CLK_NO_EVT: assert property (@(posedge clk) disable iff (!rstN)
    (!eventMode && !tickEn && !wrEn) |=> $stable(allQ)); // R11
endmodule

bind rtc_count_chain rtc_chain_chk i_chk (.*);

// File: tb/test_rtc_count_chain.sv
`timescale 1ns/1ps
module test_rtc_count_chain;
  localparam int NV = 17;
  // {hun,sec,min,hour,ydate,wmon} before, then expected after one tick
  localparam logic [95:0] VEC [NV] = '{
    96'h00_00_00_00_01_01_01_00_00_00_01_01, // R2
    96'h99_59_00_00_01_01_00_00_01_00_01_01, // R2
    96'h99_58_00_00_01_01_00_59_00_00_01_01, // R2
    96'h99_59_59_23_01_01_00_00_00_00_02_21, // R3
    96'h99_59_59_91_01_01_00_00_00_D2_01_01, // R4
    96'h99_59_59_D2_01_01_00_00_00_C1_01_01, // R4
    96'h99_59_59_D1_01_01_00_00_00_92_02_21, // R4
    96'h99_59_59_92_01_01_00_00_00_81_01_01, // R4
    96'h99_59_59_23_30_04_00_00_00_00_01_25, // R5
    96'h99_59_59_23_31_01_00_00_00_00_01_22, // R5
    96'h99_59_59_23_30_08_00_00_00_00_31_28, // R5
    96'h99_59_59_23_30_11_00_00_00_00_01_32, // R5
    96'h99_59_59_23_28_02_00_00_00_00_29_22, // R6
    96'h99_59_59_23_68_02_00_00_00_00_41_23, // R6
    96'h99_59_59_23_29_02_00_00_00_00_01_23, // R6
    96'h99_59_59_23_F1_D2_00_00_00_00_01_01, // R7
    96'h99_59_59_23_71_52_00_00_00_00_81_61  // R7
  };
  localparam string VREQ [NV] = '{"R2","R2","R2","R3","R4","R4","R4","R4",
    "R5","R5","R5","R5","R6","R6","R6","R7","R7"};

  logic clk = 1'b0, rstN = 1'b0;
  logic tickEn = 1'b0, eventEn = 1'b0, eventMode = 1'b0, stopCount = 1'b0, wrEn = 1'b0;
  logic [2:0] wrAddr = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] hundredthsQ, secondsQ, minutesQ, hoursQ, yearDateQ, dayMonthQ;
  logic [47:0] obs, snap;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  rtc_count_chain i_rtc_count_chain (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .eventEn(eventEn), .eventMode(eventMode),
    .stopCount(stopCount), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hundredthsQ(hundredthsQ), .secondsQ(secondsQ), .minutesQ(minutesQ),
    .hoursQ(hoursQ), .yearDateQ(yearDateQ), .dayMonthQ(dayMonthQ)
  );
  assign obs = {hundredthsQ, secondsQ, minutesQ, hoursQ, yearDateQ, dayMonthQ};

  task automatic check(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic tk, input logic ev, input logic we,
                     input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    tickEn = tk; eventEn = ev; wrEn = we; wrAddr = a; wrData = d;
    @(negedge clk);
    tickEn = 1'b0; eventEn = 1'b0; wrEn = 1'b0;
  endtask

  task automatic load(input logic [47:0] s);
    for (int r = 0; r < 6; r++) cyc(1'b0, 1'b0, 1'b1, 3'(r + 1), s[47 - 8*r -: 8]);
  endtask

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: got hung expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", obs, 48'h00_00_00_00_01_01);

    cyc(1'b0, 1'b1, 1'b0, 3'd0, 8'h00);       // R11 event pulse in clock mode
    check("R11", obs, 48'h00_00_00_00_01_01);

    stopCount = 1'b1;
    cyc(1'b1, 1'b1, 1'b0, 3'd0, 8'h00);       // R8 tick while stopped
    check("R8", obs, 48'h00_00_00_00_01_01);
    stopCount = 1'b0;

    for (int v = 0; v < NV; v++) begin
      load(VEC[v][95:48]);
      cyc(1'b1, 1'b0, 1'b0, 3'd0, 8'h00);
      check(VREQ[v], obs, VEC[v][47:0]);
    end

    // R9: write with a simultaneous tick
    load(48'h10_00_00_05_01_01);
    cyc(1'b1, 1'b0, 1'b1, 3'd2, 8'h45);
    check("R9", obs, 48'h10_45_00_05_01_01);
    cyc(1'b0, 1'b0, 1'b1, 3'd0, 8'h77);
    cyc(1'b0, 1'b0, 1'b1, 3'd7, 8'h77);
    check("R9", obs, 48'h10_45_00_05_01_01);

    // R10: event counter
    eventMode = 1'b1;
    load(48'h99_99_12_05_01_01);
    cyc(1'b0, 1'b1, 1'b0, 3'd0, 8'h00);
    check("R10", obs, 48'h00_00_13_05_01_01);
    cyc(1'b1, 1'b0, 1'b0, 3'd0, 8'h00);
    check("R10", obs, 48'h00_00_13_05_01_01);
    cyc(1'b0, 1'b1, 1'b0, 3'd0, 8'h00);
    check("R10", obs, 48'h01_00_13_05_01_01);
    load(48'h99_99_99_05_01_01);
    cyc(1'b0, 1'b1, 1'b0, 3'd0, 8'h00);
    check("R10", obs, 48'h00_00_00_05_01_01);
    stopCount = 1'b1;
    snap = obs;
    cyc(1'b0, 1'b1, 1'b0, 3'd0, 8'h00);
    check("R8", obs, snap);
    stopCount = 1'b0;
    eventMode = 1'b0;

    $display("%0d/%0d checks passed", checks - fails, checks);
    done = 1'b1;
    $finish;
  end
endmodule